// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps the time of day and the calendar date as packed-BCD byte registers and advances them by one second on every one-second tick pulse. Seconds roll into minutes, minutes into hours, and the end of a day advances both a weekday counter and the day of the month. Month lengths follow the calendar, with leap years for the two-digit year range 00 to 99. When the year wraps, a century bit in the month register flips.

The hour register runs in either a 24-hour format or a 12-hour format with a PM marker. The choice is made by what software writes into it. A stop control freezes the count. While it is asserted, a sticky stop flag is raised, and software can clear that flag later.

Software loads registers through a write strobe and reads any register back through a combinational read port. The write port is a single-cycle strobe. It has no back-pressure and always completes on the clock edge where it is sampled. A write to any time or date register in the same cycle as a tick takes priority, and that tick is discarded.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the registers read as follows:
  - seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), weekday 0x01, date 0x01, month 0x01 (century 0), year 0x00;
  - control 0x00;
  - status 0x80.
- R2: The register addresses are:
  - 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year;
  - 0xE control, 0xF status.

  A write lands on the next clock edge. `rd_data` shows the addressed register combinationally. Any other address reads 0x00, and a write to it changes nothing.
- R3: Seconds and minutes count 00 to 59 in BCD (0x09 is followed by 0x10). Passing 59 wraps the field to 00 and carries into the next field.
- R4: In 24-hour mode, the hour register holds a BCD value in bits 5:0 that counts 00 to 23. The step from 23 to 00 ends the day.
- R5: Writing bit 6 of the hour register as 1 selects 12-hour mode. In that mode:
  - bit 5 is the PM marker and bits 4:0 hold the BCD hour;
  - the hour sequence is 12, 01, ..., 11;
  - the step from 11 to 12 flips PM;
  - the day ends only on the step from 11 PM to 12 AM.
- R6: The weekday counts 1 to 7 and returns to 1 at the end of a day, in the same cycle as the date advances.
- R7: The date counts from 01 up to the month length and then returns to 01 while the month advances. The month length is 30 for months 04, 06, 09 and 11, 31 for the other months except February, and 28 or 29 for February (month 02).
- R8: February has 29 days when the BCD year, taken as a number, is divisible by 4 (00 included). Otherwise it has 28.
- R9: The month counts 01 to 12 in bits 4:0 of the month register. Month 12 wraps to 01 and advances the year. The year counts 00 to 99, and its wrap to 00 inverts the century bit, which is bit 7 of the month register.
- R10: Bit 7 of the control register stops the count when it is 1. While it is 1, ticks change no register and status bit 7 is set on every clock.
- R11: Writing status bit 7 as 0 clears it and writing it as 1 leaves it unchanged. A clear has no effect while the count is stopped, because setting dominates.
- R12: A write to any register at addresses 0 to 6 in the same cycle as a tick stores the written value, and that tick advances nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Addressed register, combinational |

## Verification
Every register change is due on the first rising edge after the cycle in which the tick or write strobe is presented. `rd_data` follows the address with no register in between. The bench therefore raises its stimulus just after a falling edge and drops it at the next falling edge. It reads back 1 ns after that falling edge, which is half a period after the edge that updated the state, so each check sees exactly one advance. For the cases that must not change anything (a stopped count, a write that wins over a tick, an unmapped address), the bench reads back the register that could have changed.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 4;
  typedef logic [REG_W-1:0] byte_t;

  localparam logic [ADDR_W-1:0] A_SEC  = 4'h0;
  localparam logic [ADDR_W-1:0] A_MIN  = 4'h1;
  localparam logic [ADDR_W-1:0] A_HOUR = 4'h2;
  localparam logic [ADDR_W-1:0] A_WDAY = 4'h3;
  localparam logic [ADDR_W-1:0] A_DATE = 4'h4;
  localparam logic [ADDR_W-1:0] A_MON  = 4'h5;
  localparam logic [ADDR_W-1:0] A_YEAR = 4'h6;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'hE;
  localparam logic [ADDR_W-1:0] A_STAT = 4'hF;

  // Leap test on a two-digit BCD year: value = 10*t + u, and 10*t = 2*t (mod 4)
  function automatic logic is_leap(byte_t y);
    logic [4:0] s;
    s = 5'({1'b0, y[7:4]} << 1) + 5'(y[3:0]);
    return (s[1:0] == 2'b00);
  endfunction

  // Last BCD day of a month
  function automatic byte_t last_day(byte_t m, byte_t y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_bcd_cnt.sv
module cal_bcd_cnt #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] FLOOR   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic [W-1:0] ceil,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q,
  output logic         wrap
);
  logic [W-1:0] nxt;

  assign wrap = inc && (q >= ceil);

  always_comb begin
    if (q[3:0] >= 4'd9) nxt = {q[W-1:4] + 1'b1, 4'h0};
    else                nxt = {q[W-1:4], q[3:0] + 4'h1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_VAL;
    else if (load) q <= load_val;
    else if (wrap) q <= FLOOR;
    else if (inc)  q <= nxt;
  end

  // R12
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(load_val));
endmodule

// File: rtl/cal_hour_cnt.sv
module cal_hour_cnt (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       load,
  input  logic [7:0] load_val,
  output logic [7:0] hour_reg,
  output logic       day_end
);
  logic       mode12_q;
  logic       pm_q;
  logic [5:0] val_q;
  logic [5:0] nxt;

  always_comb begin
    if (val_q[3:0] >= 4'd9) nxt = {val_q[5:4] + 2'd1, 4'h0};
    else                    nxt = {val_q[5:4], val_q[3:0] + 4'h1};
  end

  assign hour_reg = mode12_q ? {1'b0, 1'b1, pm_q, val_q[4:0]} : {2'b00, val_q};
  assign day_end  = inc && (mode12_q ? (val_q == 6'h11 && pm_q) : (val_q >= 6'h23));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode12_q <= 1'b0;
      pm_q     <= 1'b0;
      val_q    <= 6'h00;
    end else if (load) begin
      mode12_q <= load_val[6];
      pm_q     <= load_val[6] & load_val[5];
      val_q    <= load_val[6] ? {1'b0, load_val[4:0]} : load_val[5:0];
    end else if (inc) begin
      if (!mode12_q) begin
        val_q <= (val_q >= 6'h23) ? 6'h00 : nxt;
      end else if (val_q >= 6'h12) begin
        val_q <= 6'h01;
      end else if (val_q == 6'h11) begin
        val_q <= 6'h12;
        pm_q  <= ~pm_q;
      end else begin
        val_q <= nxt;
      end
    end
  end

  // R5
  pm_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !load && mode12_q && val_q == 6'h11 |=> pm_q != $past(pm_q));
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data
);
  logic  stop_q, osf_q, cent_q;
  logic  time_wr, adv;
  logic  sec_wrap, min_wrap, day_end, wday_wrap, date_wrap, mon_wrap, year_wrap;
  byte_t sec_q, min_q, hour_reg, wday_q, date_q, mon_q, year_q;
  byte_t date_ceil;

  assign time_wr   = wr_en && (wr_addr <= A_YEAR);
  assign adv       = tick && !stop_q && !time_wr;
  assign date_ceil = last_day(mon_q, year_q);

  cal_bcd_cnt #(.W(REG_W), .RST_VAL(8'h00), .FLOOR(8'h00)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc(adv), .ceil(8'h59),
    .load(wr_en && wr_addr == A_SEC), .load_val({1'b0, wr_data[6:0]}),
    .q(sec_q), .wrap(sec_wrap));

  cal_bcd_cnt #(.W(REG_W), .RST_VAL(8'h00), .FLOOR(8'h00)) u_min (
    .clk(clk), .rst_n(rst_n), .inc(sec_wrap), .ceil(8'h59),
    .load(wr_en && wr_addr == A_MIN), .load_val({1'b0, wr_data[6:0]}),
    .q(min_q), .wrap(min_wrap));

  cal_hour_cnt u_hour (
    .clk(clk), .rst_n(rst_n), .inc(min_wrap),
    .load(wr_en && wr_addr == A_HOUR), .load_val(wr_data),
    .hour_reg(hour_reg), .day_end(day_end));

  cal_bcd_cnt #(.W(REG_W), .RST_VAL(8'h01), .FLOOR(8'h01)) u_wday (
    .clk(clk), .rst_n(rst_n), .inc(day_end), .ceil(8'h07),
    .load(wr_en && wr_addr == A_WDAY), .load_val({5'b0, wr_data[2:0]}),
    .q(wday_q), .wrap(wday_wrap));

  cal_bcd_cnt #(.W(REG_W), .RST_VAL(8'h01), .FLOOR(8'h01)) u_date (
    .clk(clk), .rst_n(rst_n), .inc(day_end), .ceil(date_ceil),
    .load(wr_en && wr_addr == A_DATE), .load_val({2'b0, wr_data[5:0]}),
    .q(date_q), .wrap(date_wrap));

  cal_bcd_cnt #(.W(REG_W), .RST_VAL(8'h01), .FLOOR(8'h01)) u_mon (
    .clk(clk), .rst_n(rst_n), .inc(date_wrap), .ceil(8'h12),
    .load(wr_en && wr_addr == A_MON), .load_val({3'b0, wr_data[4:0]}),
    .q(mon_q), .wrap(mon_wrap));

  cal_bcd_cnt #(.W(REG_W), .RST_VAL(8'h00), .FLOOR(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .inc(mon_wrap), .ceil(8'h99),
    .load(wr_en && wr_addr == A_YEAR), .load_val(wr_data),
    .q(year_q), .wrap(year_wrap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      osf_q  <= 1'b1;
      cent_q <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) stop_q <= wr_data[7];
      if (stop_q) osf_q <= 1'b1;
      else if (wr_en && wr_addr == A_STAT && !wr_data[7]) osf_q <= 1'b0;
      if (wr_en && wr_addr == A_MON) cent_q <= wr_data[7];
      else if (year_wrap)            cent_q <= ~cent_q;
    end
  end

  always_comb begin
    case (rd_addr)
      A_SEC:   rd_data = sec_q;
      A_MIN:   rd_data = min_q;
      A_HOUR:  rd_data = hour_reg;
      A_WDAY:  rd_data = wday_q;
      A_DATE:  rd_data = date_q;
      A_MON:   rd_data = {cent_q, mon_q[6:0]};
      A_YEAR:  rd_data = year_q;
      A_CTRL:  rd_data = {stop_q, 7'b0};
      A_STAT:  rd_data = {osf_q, 7'b0};
      default: rd_data = '0;
    endcase
  end

  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q && !time_wr |=> $stable(sec_q));
  // R10
  osf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> osf_q);
  // R9
  cent_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    year_wrap && !(wr_en && wr_addr == A_MON) |=> cent_q != $past(cent_q));
  // R6
  wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wday_wrap && !time_wr |=> wday_q == 8'h01);
  // R3
  min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && sec_q != 8'h59 |=> $stable(min_q));
endmodule

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = 4'h0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] rd_addr = 4'h0;
  logic [7:0] rd_data;
  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  bcd_calendar u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick1();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    rd_addr = a; #1;
    nchk++;
    if (rd_data !== exp) begin
      nerr++;
      $display("FAIL %s reg %h: actual %h expected %h", tag, a, rd_data, exp);
    end
  endtask

  task automatic set_time(input logic [7:0] s, m, h, wd, d, mo, y);
    wr(4'h0, s); wr(4'h1, m); wr(4'h2, h); wr(4'h3, wd);
    wr(4'h4, d); wr(4'h5, mo); wr(4'h6, y);
  endtask

  task automatic t_reset();
    chk("R1", 4'h0, 8'h00); chk("R1", 4'h1, 8'h00); chk("R1", 4'h2, 8'h00);
    chk("R1", 4'h3, 8'h01); chk("R1", 4'h4, 8'h01); chk("R1", 4'h5, 8'h01);
    chk("R1", 4'h6, 8'h00); chk("R1", 4'hE, 8'h00); chk("R1", 4'hF, 8'h80);
  endtask

  task automatic t_sec_min();
    set_time(8'h09, 8'h00, 8'h05, 8'h01, 8'h01, 8'h01, 8'h00);
    chk("R2", 4'h2, 8'h05);
    tick1(); chk("R3", 4'h0, 8'h10); chk("R3", 4'h1, 8'h00);
    set_time(8'h59, 8'h59, 8'h05, 8'h01, 8'h01, 8'h01, 8'h00);
    tick1(); chk("R3", 4'h0, 8'h00); chk("R3", 4'h1, 8'h00); chk("R4", 4'h2, 8'h06);
    set_time(8'h59, 8'h12, 8'h05, 8'h01, 8'h01, 8'h01, 8'h00);
    tick1(); chk("R3", 4'h1, 8'h13);
  endtask

  task automatic t_midnight();
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    tick1();
    chk("R4", 4'h2, 8'h00); chk("R6", 4'h3, 8'h01); chk("R7", 4'h4, 8'h01);
    chk("R9", 4'h5, 8'h81); chk("R9", 4'h6, 8'h00);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h31, 8'h92, 8'h99);
    tick1(); chk("R9", 4'h5, 8'h01); chk("R6", 4'h3, 8'h04);
  endtask

  task automatic t_12h();
    set_time(8'h59, 8'h59, 8'h71, 8'h03, 8'h15, 8'h06, 8'h24);
    tick1(); chk("R5", 4'h2, 8'h52); chk("R5", 4'h4, 8'h16); chk("R6", 4'h3, 8'h04);
    set_time(8'h59, 8'h59, 8'h51, 8'h03, 8'h15, 8'h06, 8'h24);
    tick1(); chk("R5", 4'h2, 8'h72); chk("R5", 4'h4, 8'h15);
    set_time(8'h59, 8'h59, 8'h52, 8'h03, 8'h15, 8'h06, 8'h24);
    tick1(); chk("R5", 4'h2, 8'h41);
    set_time(8'h59, 8'h59, 8'h72, 8'h03, 8'h15, 8'h06, 8'h24);
    tick1(); chk("R5", 4'h2, 8'h61); chk("R5", 4'h4, 8'h15);
  endtask

  task automatic t_month();
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h21);
    tick1(); chk("R7", 4'h4, 8'h01); chk("R7", 4'h5, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h05, 8'h21);
    tick1(); chk("R7", 4'h4, 8'h31); chk("R7", 4'h5, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h05, 8'h21);
    tick1(); chk("R7", 4'h4, 8'h01); chk("R7", 4'h5, 8'h06);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h11, 8'h21);
    tick1(); chk("R7", 4'h4, 8'h01); chk("R7", 4'h5, 8'h12);
  endtask

  task automatic t_leap();
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    tick1(); chk("R8", 4'h4, 8'h29); chk("R8", 4'h5, 8'h02);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    tick1(); chk("R8", 4'h4, 8'h01); chk("R8", 4'h5, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    tick1(); chk("R8", 4'h4, 8'h01); chk("R8", 4'h5, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    tick1(); chk("R8", 4'h4, 8'h29);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h10);
    tick1(); chk("R8", 4'h4, 8'h01);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h12);
    tick1(); chk("R8", 4'h4, 8'h29);
  endtask

  task automatic t_stop();
    wr(4'hF, 8'h00); chk("R11", 4'hF, 8'h00);
    wr(4'hF, 8'h80); chk("R11", 4'hF, 8'h00);
    wr(4'h0, 8'h20);
    wr(4'hE, 8'h80); chk("R10", 4'hE, 8'h80);
    tick1(); chk("R10", 4'h0, 8'h20); chk("R10", 4'hF, 8'h80);
    wr(4'hF, 8'h00); chk("R11", 4'hF, 8'h80);
    wr(4'hE, 8'h00); wr(4'hF, 8'h00); chk("R11", 4'hF, 8'h00);
    tick1(); chk("R10", 4'h0, 8'h21);
  endtask

  task automatic t_restart();
    wr(4'h0, 8'h10);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'h0; wr_data = 8'h30; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    chk("R12", 4'h0, 8'h30);
    tick1(); chk("R12", 4'h0, 8'h31);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'h1; wr_data = 8'h05; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    chk("R12", 4'h0, 8'h31); chk("R12", 4'h1, 8'h05);
  endtask

  task automatic t_unmapped();
    wr(4'h0, 8'h44);
    wr(4'h8, 8'hFF); chk("R2", 4'h8, 8'h00); chk("R2", 4'h0, 8'h44);
    wr(4'h3, 8'h05); chk("R2", 4'h3, 8'h05);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sec_min();
    t_midnight();
    t_12h();
    t_month();
    t_leap();
    t_stop();
    t_restart();
    t_unmapped();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired (all of R1 to R12 unfinished)");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule